// File: doc/BRIEF.md
# Status LED Fault Blink-Code Generator

This block drives one red status LED so that it shows the most urgent fault or configuration condition of a companion FPGA and of the board's power system. Its inputs are the FPGA's reset-hold line and configuration-error line (both active low), its configuration-complete line, a power-sequencer fault flag and a clock-generator (PLL/oscillator) fault flag. All five are asynchronous and pass through two-flop synchronisers. Generating these flags and configuring the FPGA are outside this block.

Time is divided into frames of eight equal slots. Each slot is `SLOT_CYCLES` clocks long; the default of 6,250,000 gives 250 ms per slot at 25 MHz. A fault is shown by lighting the first N slots of each frame and leaving the others dark. A "not yet configured" FPGA with no fault holds the LED on. With no condition active the LED is off. The condition shown is chosen only at the start of each frame, so a frame never holds a mix of two patterns.

All pins are plain level signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `fault_blink_led`

## Requirements
- R1: Each slot lasts exactly `SLOT_CYCLES` clocks and a frame holds `SLOTS` (8) slots. The pattern repeats frame after frame for as long as the inputs stay the same.
- R2: A blink code of N lights the LED during slots 0..N-1 of the frame and keeps it dark during slots N..7.
- R3: `fpga_hold_n_i` low (FPGA held in reset) selects N = 1.
- R4: `fpga_cfgerr_n_i` low (configuration error) selects N = 2.
- R5: `pwrseq_fault_i` high selects N = 3.
- R6: `clkgen_fault_i` high selects N = 4.
- R7: `fpga_loaded_i` low with none of R3–R6 active holds the LED on for the whole frame.
- R8: Priority from highest to lowest is power fault, clock-generator fault, configuration error, reset hold, then not-loaded. Only the highest active condition is shown.
- R9: With no condition active the LED stays dark for the whole frame.
- R10: A change of inputs in the middle of a frame does not alter the rest of that frame. The new code appears from the next frame onward.
- R11: An input change made in the clock cycle just before a frame's first slot is not shown in that frame, because of the two synchroniser stages. It is shown in the following frame.
- R12: While `rst_i` is high the LED is dark. The first frame begins in the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 25 MHz nominal |
| rst_i | input | 1 | Synchronous reset, active high |
| fpga_hold_n_i | input | 1 | FPGA held in reset when low (asynchronous) |
| fpga_cfgerr_n_i | input | 1 | FPGA configuration error when low (asynchronous) |
| fpga_loaded_i | input | 1 | FPGA configuration complete when high (asynchronous) |
| pwrseq_fault_i | input | 1 | Power-sequencer fault, active high (asynchronous) |
| clkgen_fault_i | input | 1 | PLL/oscillator configuration fault, active high (asynchronous) |
| status_led_o | output | 1 | LED drive, high = lit |

## Verification
A slot counter or prescaler that is out of step shows up within one slot as a lit run of the wrong length, or as a lit run that starts or ends on the wrong cycle. A corrupted latched code shows up as a wrong lit count in the very next slot. It then persists until the next frame boundary reloads the code. A bad priority or a bad synchroniser shows up one frame after the stimulus, as the wrong pattern or as a pattern that arrives one frame early. Each frame is therefore compared cycle by cycle against a pattern worked out from the input levels.

// File: rtl/blink_pkg.sv
package blink_pkg;

  // Which condition the LED is currently asked to show
  typedef enum logic [2:0] {
    SRC_IDLE    = 3'd0,
    SRC_UNLOAD  = 3'd1,
    SRC_HOLD    = 3'd2,
    SRC_CFGERR  = 3'd3,
    SRC_PWR     = 3'd4,
    SRC_CLKGEN  = 3'd5
  } fault_src_e;

  // Lit-slot counts per condition
  localparam int unsigned LIT_HOLD   = 1;
  localparam int unsigned LIT_CFGERR = 2;
  localparam int unsigned LIT_PWR    = 3;
  localparam int unsigned LIT_CLKGEN = 4;

  // Idle level of the synchronised input vector
  // bit0 hold_n, bit1 cfgerr_n, bit2 loaded, bit3 pwr, bit4 clkgen
  localparam logic [4:0] IN_IDLE = 5'b00111;

  function automatic int unsigned src_lit(fault_src_e s);
    case (s)
      SRC_HOLD:   return LIT_HOLD;
      SRC_CFGERR: return LIT_CFGERR;
      SRC_PWR:    return LIT_PWR;
      SRC_CLKGEN: return LIT_CLKGEN;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/blink_sync2.sv
module blink_sync2 #(
  parameter int unsigned     WIDTH   = 5,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic safe_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        meta_q <= RST_VAL[b];
        safe_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        safe_q <= meta_q;
      end
    end
    assign q_o[b] = safe_q;
  end

endmodule

// File: rtl/blink_fault_prio.sv
module blink_fault_prio
  import blink_pkg::*;
(
  input  logic       hold_n_i,
  input  logic       cfgerr_n_i,
  input  logic       loaded_i,
  input  logic       pwr_i,
  input  logic       clkgen_i,
  output fault_src_e src_o
);

  always_comb begin
    if (pwr_i)            src_o = SRC_PWR;
    else if (clkgen_i)    src_o = SRC_CLKGEN;
    else if (!cfgerr_n_i) src_o = SRC_CFGERR;
    else if (!hold_n_i)   src_o = SRC_HOLD;
    else if (!loaded_i)   src_o = SRC_UNLOAD;
    else                  src_o = SRC_IDLE;
  end

endmodule

// File: rtl/blink_slot_timer.sv
module blink_slot_timer #(
  parameter int unsigned SLOT_CYCLES = 6_250_000,
  parameter int unsigned SLOTS       = 8,
  localparam int unsigned PRE_W      = $clog2(SLOT_CYCLES),
  localparam int unsigned IDX_W      = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [IDX_W-1:0] slot_idx_o,
  output logic             frame_load_o
);

  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(SLOT_CYCLES - 1);
  localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(SLOTS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [IDX_W-1:0] idx_q;
  logic             slot_end;

  assign slot_end = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pre_q <= '0;
      idx_q <= '0;
    end else begin
      pre_q <= slot_end ? '0 : pre_q + 1'b1;
      if (slot_end) idx_q <= (idx_q == SLOT_LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign slot_idx_o   = idx_q;
  assign frame_load_o = (pre_q == '0) && (idx_q == '0);

endmodule

// File: rtl/blink_pattern.sv
module blink_pattern
  import blink_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned LIT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             frame_load_i,
  input  logic [IDX_W-1:0] slot_idx_i,
  input  fault_src_e       req_src_i,
  output logic [LIT_W-1:0] lit_o,
  output logic             steady_o,
  output logic             led_o
);

  logic [LIT_W-1:0] lit_q, lit_req, lit_use;
  logic             steady_q, steady_req, steady_use;
  logic             led_q;

  assign lit_req    = LIT_W'(src_lit(req_src_i));
  assign steady_req = (req_src_i == SRC_UNLOAD);

  // On a boundary the fresh request drives this frame's first slot directly
  assign lit_use    = frame_load_i ? lit_req    : lit_q;
  assign steady_use = frame_load_i ? steady_req : steady_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lit_q    <= '0;
      steady_q <= 1'b0;
      led_q    <= 1'b0;
    end else begin
      if (frame_load_i) begin
        lit_q    <= lit_req;
        steady_q <= steady_req;
      end
      led_q <= steady_use || (LIT_W'(slot_idx_i) < lit_use);
    end
  end

  assign lit_o    = lit_q;
  assign steady_o = steady_q;
  assign led_o    = led_q;

endmodule

// File: rtl/fault_blink_led.sv
module fault_blink_led
  import blink_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 6_250_000,
  parameter int unsigned SLOTS       = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fpga_hold_n_i,
  input  logic fpga_cfgerr_n_i,
  input  logic fpga_loaded_i,
  input  logic pwrseq_fault_i,
  input  logic clkgen_fault_i,
  output logic status_led_o
);

  localparam int unsigned IDX_W = $clog2(SLOTS);
  localparam int unsigned LIT_W = $clog2(SLOTS + 1);

  logic [4:0]       raw_in, sync_in;
  fault_src_e       req_src;
  logic [IDX_W-1:0] slot_idx;
  logic             frame_load;
  logic [LIT_W-1:0] lit_q;
  logic             steady_q;

  assign raw_in = {clkgen_fault_i, pwrseq_fault_i, fpga_loaded_i,
                   fpga_cfgerr_n_i, fpga_hold_n_i};

  blink_sync2 #(.WIDTH(5), .RST_VAL(IN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  blink_fault_prio u_prio (
    .hold_n_i   (sync_in[0]),
    .cfgerr_n_i (sync_in[1]),
    .loaded_i   (sync_in[2]),
    .pwr_i      (sync_in[3]),
    .clkgen_i   (sync_in[4]),
    .src_o      (req_src)
  );

  blink_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES), .SLOTS(SLOTS)) u_timer (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .slot_idx_o   (slot_idx),
    .frame_load_o (frame_load)
  );

  blink_pattern #(.IDX_W(IDX_W), .LIT_W(LIT_W)) u_pat (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .frame_load_i (frame_load),
    .slot_idx_i   (slot_idx),
    .req_src_i    (req_src),
    .lit_o        (lit_q),
    .steady_o     (steady_q),
    .led_o        (status_led_o)
  );

endmodule

// File: rtl/fault_blink_led_chk.sv
module fault_blink_led_chk #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned LIT_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             led_i,
  input logic             frame_load_i,
  input logic [IDX_W-1:0] slot_idx_i,
  input logic [LIT_W-1:0] lit_i,
  input logic             steady_i
);

  logic in_lit;
  assign in_lit = LIT_W'(slot_idx_i) < lit_i;

  // R12: reset keeps the LED dark
  assert_reset_dark_R12: assert property (@(posedge clk_i)
    rst_i |=> !led_i);

  // R10: the latched code only moves on a frame boundary
  assert_code_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !frame_load_i |=> ($stable(lit_i) && $stable(steady_i)));

  // R2: head slots lit
  assert_head_lit_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!frame_load_i && !steady_i && in_lit) |=> led_i);

  // R2 / R9: tail slots dark
  assert_tail_dark_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!frame_load_i && !steady_i && !in_lit) |=> !led_i);

  // R7: steady-on state
  assert_steady_on_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!frame_load_i && steady_i) |=> led_i);

  // R8: steady and a blink code are never latched together
  assert_one_code_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !(steady_i && (lit_i != '0)));

endmodule

bind fault_blink_led fault_blink_led_chk #(.IDX_W(IDX_W), .LIT_W(LIT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .led_i        (status_led_o),
  .frame_load_i (frame_load),
  .slot_idx_i   (slot_idx),
  .lit_i        (lit_q),
  .steady_i     (steady_q)
);

// File: tb/fault_blink_led_tb.sv
module fault_blink_led_tb;

  localparam int S = 4;
  localparam int N = 8;
  localparam int F = S * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_n = 1'b1, cfgerr_n = 1'b1, loaded = 1'b1, pwr = 1'b0, clkgen = 1'b0;
  logic led;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fault_blink_led #(.SLOT_CYCLES(S), .SLOTS(N)) u_dut (
    .clk_i           (clk),
    .rst_i           (rst),
    .fpga_hold_n_i   (hold_n),
    .fpga_cfgerr_n_i (cfgerr_n),
    .fpga_loaded_i   (loaded),
    .pwrseq_fault_i  (pwr),
    .clkgen_fault_i  (clkgen),
    .status_led_o    (led)
  );

  // Count of clock edges since reset release
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lit();
    if (pwr)            return 3;
    else if (clkgen)    return 4;
    else if (!cfgerr_n) return 2;
    else if (!hold_n)   return 1;
    else                return 0;
  endfunction

  function automatic string tag_of();
    int act;
    act = int'(pwr) + int'(clkgen) + int'(!cfgerr_n) + int'(!hold_n);
    if (act > 1)        return "R8";
    else if (pwr)       return "R5";
    else if (clkgen)    return "R6";
    else if (!cfgerr_n) return "R4";
    else if (!hold_n)   return "R3";
    else if (!loaded)   return "R7";
    else                return "R9";
  endfunction

  // Wait for the falling edge that follows edge n
  task automatic wait_n(input int n);
    while (cyc != n + 1) @(negedge clk);
  endtask

  task automatic next_base(output int b);
    int now_n;
    now_n = cyc - 1;
    b = ((now_n + 3) / F + 1) * F;
  endtask

  // Compare every cycle of slots k0..k1 of the frame starting at edge b
  task automatic check_frame(input int b, input int lit, input bit steady,
                             input string tag, input int k0, input int k1);
    for (int k = k0; k <= k1; k++) begin
      int bad = 0;
      int act = 0;
      int exp;
      exp = (steady || (k < lit)) ? 1 : 0;
      for (int c = 0; c < S; c++) begin
        wait_n(b + k * S + c);
        if (led !== exp[0]) begin
          bad++;
          act = int'(led);
        end else if (bad == 0) act = int'(led);
      end
      check(bad == 0, {tag, " R1 R2 slot"}, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int b;
    int lit;
    bit st;
    repeat (3) @(negedge clk);
    check(led == 1'b0, "R12 reset", int'(led), 0);
    rst = 1'b0;

    // R12: first frame starts right after release, idle inputs -> dark
    check_frame(0, 0, 1'b0, "R12", 0, N - 1);

    // Exhaustive sweep over all 32 input combinations (R3..R9)
    for (int v = 0; v < 32; v++) begin
      {clkgen, pwr, loaded, cfgerr_n, hold_n} = v[4:0];
      lit = exp_lit();
      st  = (lit == 0) && !loaded;
      next_base(b);
      check_frame(b, lit, st, tag_of(), 0, N - 1);
      check_frame(b + F, lit, st, tag_of(), 0, N - 1);
    end

    // R10: mid-frame change does not disturb the running frame
    {clkgen, pwr, loaded, cfgerr_n, hold_n} = 5'b10111;
    next_base(b);
    check_frame(b, 4, 1'b0, "R10", 0, 1);
    {clkgen, pwr} = 2'b01;
    check_frame(b, 4, 1'b0, "R10", 2, N - 1);
    check_frame(b + F, 3, 1'b0, "R10", 0, N - 1);

    // R11: change one cycle before a boundary is deferred a frame
    {clkgen, pwr, loaded, cfgerr_n, hold_n} = 5'b00111;
    next_base(b);
    check_frame(b, 0, 1'b0, "R11", 0, N - 1);
    clkgen = 1'b1;
    check_frame(b + F, 0, 1'b0, "R11", 0, 0);
    check_frame(b + 2 * F, 4, 1'b0, "R11", 0, N - 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule